// File: doc/BRIEF.md
# Half-Step Pulse-Swallow Divider Controller

This block steers the feedback divider of a fractional-N frequency synthesizer. It runs on the output clock of a dual-modulus prescaler that divides its input by 4, or by 4.5 while the block raises its mode line. The 4.5 setting is reached by triggering on both input edges, so seen on one edge its output periods alternate between 4 and 5 input cycles. The block counts prescaler output cycles and decides, for each of them, which modulus the prescaler uses. Once per division cycle it emits a one-cycle divided pulse toward the phase detector.

The division command is written as twice the wanted ratio. Its upper six bits give the program count P and its lower three bits give the swallow count S, so the ratio is 4·P + 0.5·S. With P between 9 and 20, the ratio covers 36 to 83.5 in half steps. During each division cycle the first S prescaler periods run at 4.5 and the remaining P − S at 4. Since P is never below 9 and S never above 7, P ≥ S always holds. A new command is taken only at the reload that ends a division cycle. A command outside the legal span is clamped to the nearest end.

Top module: `hsdiv_ctrl`

## Requirements
- R1: The command `ratio_cmd` holds twice the division ratio. Bits [8:3] give P, bits [2:0] give S, and the ratio is 4·P + 0.5·S prescaler-input periods.
- R2: Successive `div_out` pulses are exactly P prescaler output cycles apart. With the prescaler attached, this spacing is 8·P + S half periods of the prescaler input.
- R3: In every division cycle, `mode_out` is high for the first S prescaler output cycles, starting with the cycle that begins at the reload. It is low for the remaining P − S cycles and never rises again before the next reload.
- R4: `div_out` is high for exactly one prescaler output cycle per division cycle. It is never high on two consecutive cycles.
- R5: The command is sampled only at the reload edge. Changing `ratio_cmd` during a division cycle leaves that cycle's length and mode pattern unchanged, and the new value governs the following cycle.
- R6: A command below 72 acts as 72 (P = 9, S = 0). A command above 167 acts as 167 (P = 20, S = 7).
- R7: While `rst_n` is low, `div_out` and `mode_out` are 0. The first clock edge after reset is released performs a reload, which raises `div_out` and loads the current command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock; one rising edge per prescaler period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_cmd | input | 9 | Twice the division ratio: P in [8:3], S in [2:0] |
| mode_out | output | 1 | Prescaler mode: 1 selects divide-by-4.5 for the period that starts now |
| div_out | output | 1 | One-cycle divided pulse, raised at each reload |

## Verification
The controller drives a behavioural dual-edge prescaler. The interval between divided pulses is measured in half input periods, and the bench counts the mode-high periods inside each division cycle. The commands include the two extremes of the range, P = 9 with no swallow and P = 20 with S = 7, which separate a correct program count from an off-by-one reload. Mid-range commands with odd and even S show whether the half-step bit reaches the prescaler in the correct periods. Values beyond both ends test the clamp. Each command is applied right after a reload, so a design that picks up the command too early produces an interval of the wrong length and is caught.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;

   // Default geometry of the divider controller
   localparam int unsigned HSD_FRAC_W_DEF = 3;
   localparam int unsigned HSD_P_W_DEF    = 6;
   localparam int unsigned HSD_P_MIN_DEF  = 9;
   localparam int unsigned HSD_P_MAX_DEF  = 20;

   // Smallest legal command (twice the ratio) for a given geometry
   function automatic int unsigned hsd_cmd_lo(int unsigned p_min, int unsigned frac_w);
      return p_min << frac_w;
   endfunction

   // Largest legal command (twice the ratio) for a given geometry
   function automatic int unsigned hsd_cmd_hi(int unsigned p_max, int unsigned frac_w);
      return (p_max << frac_w) + ((1 << frac_w) - 1);
   endfunction

endpackage

// File: rtl/hsdiv_cmd_decode.sv
module hsdiv_cmd_decode
   import hsdiv_pkg::*;
#(
   parameter int unsigned FRAC_W = HSD_FRAC_W_DEF,
   parameter int unsigned P_W    = HSD_P_W_DEF,
   parameter int unsigned P_MIN  = HSD_P_MIN_DEF,
   parameter int unsigned P_MAX  = HSD_P_MAX_DEF,
   localparam int unsigned CMD_W = P_W + FRAC_W
) (
   input  logic [CMD_W-1:0]  cmd_i,
   output logic [P_W-1:0]    p_o,
   output logic [FRAC_W-1:0] s_o
);

   localparam int unsigned CMD_LO = hsd_cmd_lo(P_MIN, FRAC_W);
   localparam int unsigned CMD_HI = hsd_cmd_hi(P_MAX, FRAC_W);

   logic [CMD_W-1:0] cmd_lim;

   // Clamp the command into the legal span, then split it
   always_comb begin
      if (cmd_i < CMD_W'(CMD_LO))
         cmd_lim = CMD_W'(CMD_LO);
      else if (cmd_i > CMD_W'(CMD_HI))
         cmd_lim = CMD_W'(CMD_HI);
      else
         cmd_lim = cmd_i;
   end

   assign p_o = cmd_lim[CMD_W-1:FRAC_W];
   assign s_o = cmd_lim[FRAC_W-1:0];

endmodule

// File: rtl/hsdiv_cycle_cnt.sv
module hsdiv_cycle_cnt
   import hsdiv_pkg::*;
#(
   parameter int unsigned FRAC_W = HSD_FRAC_W_DEF,
   parameter int unsigned P_W    = HSD_P_W_DEF,
   parameter int unsigned P_MIN  = HSD_P_MIN_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [P_W-1:0]    p_new_i,
   input  logic [FRAC_W-1:0] s_new_i,
   output logic              reload_o,
   output logic [P_W-1:0]    idx_nx_o,
   output logic [FRAC_W-1:0] s_nx_o
);

   logic [P_W-1:0]    p_cur;
   logic [FRAC_W-1:0] s_cur;
   logic [P_W-1:0]    idx;

   // Last period of the running division cycle
   assign reload_o = (idx == (p_cur - P_W'(1)));
   assign idx_nx_o = reload_o ? '0 : idx + P_W'(1);
   assign s_nx_o   = reload_o ? s_new_i : s_cur;

   // Reset parks the index on the last period so the first edge reloads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_cur <= P_W'(P_MIN);
         s_cur <= '0;
         idx   <= P_W'(P_MIN - 1);
      end else begin
         idx <= idx_nx_o;
         if (reload_o) begin
            p_cur <= p_new_i;
            s_cur <= s_new_i;
         end
      end
   end

endmodule

// File: rtl/hsdiv_mode_gen.sv
module hsdiv_mode_gen
   import hsdiv_pkg::*;
#(
   parameter int unsigned FRAC_W = HSD_FRAC_W_DEF,
   parameter int unsigned P_W    = HSD_P_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload_i,
   input  logic [P_W-1:0]    idx_nx_i,
   input  logic [FRAC_W-1:0] s_nx_i,
   output logic              mode_o,
   output logic              div_o
);

   logic [P_W-1:0] s_wide;
   assign s_wide = P_W'(s_nx_i);

   // Mode for the period that starts at this edge; pulse marks the reload
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= 1'b0;
         div_o  <= 1'b0;
      end else begin
         mode_o <= (idx_nx_i < s_wide);
         div_o  <= reload_i;
      end
   end

endmodule

// File: rtl/hsdiv_ctrl.sv
module hsdiv_ctrl
   import hsdiv_pkg::*;
#(
   parameter int unsigned FRAC_W = HSD_FRAC_W_DEF,
   parameter int unsigned P_W    = HSD_P_W_DEF,
   parameter int unsigned P_MIN  = HSD_P_MIN_DEF,
   parameter int unsigned P_MAX  = HSD_P_MAX_DEF,
   localparam int unsigned CMD_W = P_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] ratio_cmd,
   output logic             mode_out,
   output logic             div_out
);

   // Elaboration-time checks on the geometry
   generate
      if (FRAC_W < 1)
         $error("hsdiv_ctrl: FRAC_W must be at least 1");
      if (P_MIN < 2)
         $error("hsdiv_ctrl: P_MIN must be at least 2");
      if (P_MIN < (1 << FRAC_W) - 1)
         $error("hsdiv_ctrl: P_MIN must cover the largest swallow count");
      if (P_MAX < P_MIN)
         $error("hsdiv_ctrl: P_MAX below P_MIN");
      if (P_MAX >= (1 << P_W))
         $error("hsdiv_ctrl: P_MAX does not fit in P_W bits");
   endgenerate

   logic [P_W-1:0]    p_dec;
   logic [FRAC_W-1:0] s_dec;
   logic              reload;
   logic [P_W-1:0]    idx_nx;
   logic [FRAC_W-1:0] s_nx;

   hsdiv_cmd_decode #(
      .FRAC_W (FRAC_W),
      .P_W    (P_W),
      .P_MIN  (P_MIN),
      .P_MAX  (P_MAX)
   ) u_dec (
      .cmd_i  (ratio_cmd),
      .p_o    (p_dec),
      .s_o    (s_dec)
   );

   hsdiv_cycle_cnt #(
      .FRAC_W (FRAC_W),
      .P_W    (P_W),
      .P_MIN  (P_MIN)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .p_new_i  (p_dec),
      .s_new_i  (s_dec),
      .reload_o (reload),
      .idx_nx_o (idx_nx),
      .s_nx_o   (s_nx)
   );

   hsdiv_mode_gen #(
      .FRAC_W (FRAC_W),
      .P_W    (P_W)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload_i (reload),
      .idx_nx_i (idx_nx),
      .s_nx_i   (s_nx),
      .mode_o   (mode_out),
      .div_o    (div_out)
   );

endmodule

// File: rtl/hsdiv_ctrl_chk.sv
module hsdiv_ctrl_chk
   import hsdiv_pkg::*;
#(
   parameter int unsigned FRAC_W = HSD_FRAC_W_DEF,
   parameter int unsigned P_W    = HSD_P_W_DEF,
   parameter int unsigned P_MIN  = HSD_P_MIN_DEF,
   parameter int unsigned P_MAX  = HSD_P_MAX_DEF,
   localparam int unsigned CMD_W = P_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] ratio_cmd,
   input  logic             mode_out,
   input  logic             div_out
);

   localparam int unsigned CMD_LO = hsd_cmd_lo(P_MIN, FRAC_W);
   localparam int unsigned CMD_HI = hsd_cmd_hi(P_MAX, FRAC_W);

   logic [CMD_W-1:0] cmd_q;     // command as seen at the previous edge
   logic [CMD_W-1:0] cmd_eff;   // that command after limiting
   logic [P_W:0]     per_cnt;   // periods since the last observed pulse
   logic [P_W-1:0]   p_lat;     // program count of the running cycle
   logic             armed;

   always_ff @(posedge clk) cmd_q <= ratio_cmd;

   always_comb begin
      if (cmd_q < CMD_W'(CMD_LO))      cmd_eff = CMD_W'(CMD_LO);
      else if (cmd_q > CMD_W'(CMD_HI)) cmd_eff = CMD_W'(CMD_HI);
      else                             cmd_eff = cmd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_cnt <= '0;
         p_lat   <= '0;
         armed   <= 1'b0;
      end else if (div_out) begin
         per_cnt <= (P_W+1)'(1);
         p_lat   <= cmd_eff[CMD_W-1:FRAC_W];
         armed   <= 1'b1;
      end else begin
         per_cnt <= per_cnt + (P_W+1)'(1);
      end
   end

   // R2: pulses are P prescaler cycles apart
   p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (div_out && armed) |-> (per_cnt == (P_W+1)'(p_lat)));

   // R3: once the mode line has dropped it stays low until the next reload
   p_mode_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_out |=> (div_out || !mode_out));

   // R3: the first period of a cycle swallows exactly when S is non-zero
   p_mode_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      div_out |-> (mode_out == (cmd_eff[FRAC_W-1:0] != '0)));

   // R4: the divided pulse lasts one cycle
   p_div_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      div_out |=> !div_out);

   // R7: outputs held low during reset
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r7: assert (!div_out && !mode_out);
      end
   end

endmodule

bind hsdiv_ctrl hsdiv_ctrl_chk #(
   .FRAC_W (FRAC_W),
   .P_W    (P_W),
   .P_MIN  (P_MIN),
   .P_MAX  (P_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ratio_cmd (ratio_cmd),
   .mode_out  (mode_out),
   .div_out   (div_out)
);

// File: tb/hsdiv_ctrl_tb.sv
`timescale 1ns/1ps
module hsdiv_ctrl_tb;

   logic       clk = 1'b0;      // 100 MHz prescaler input
   logic       pre_clk = 1'b0;  // prescaler output, clocks the DUT
   logic       rst_n;
   logic [8:0] ratio_cmd = 9'd72;
   logic       mode_out;
   logic       div_out;

   int n_checks = 0;
   int n_errors = 0;

   hsdiv_ctrl u_dut (
      .clk       (pre_clk),
      .rst_n     (rst_n),
      .ratio_cmd (ratio_cmd),
      .mode_out  (mode_out),
      .div_out   (div_out)
   );

   always #5 clk = ~clk;

   // Behavioural dual-edge prescaler: 8 or 9 input half periods per output period
   int hc  = 0;
   int cnt = 0;
   int lim = 8;
   always @(posedge clk or negedge clk) begin
      hc++;
      cnt++;
      if (cnt == 1) lim = (mode_out === 1'b1) ? 9 : 8;
      if (cnt == lim) begin
         cnt = 0;
         pre_clk = 1'b1;
      end else if (cnt == 4) begin
         pre_clk = 1'b0;
      end
   end

   // Scoreboard queues: half-period spacing and swallow count per cycle
   int  q_sp[$];
   int  q_s[$];
   event ev_div;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected behaviour from the requirements (R1, R6)
   task automatic push_cmd(input int cmd, input int n);
      int c, p, s;
      c = cmd;
      if (c < 72)  c = 72;   // R6 lower clamp
      if (c > 167) c = 167;  // R6 upper clamp
      p = c / 8;             // R1: bits [8:3]
      s = c % 8;             // R1: bits [2:0]
      for (int i = 0; i < n; i++) begin
         q_sp.push_back(8 * p + s);
         q_s.push_back(s);
      end
   endtask

   // Driver: new command right after a reload (R5), then n division cycles
   task automatic run(input int cmd, input int n);
      ratio_cmd = 9'(cmd);
      push_cmd(cmd, n);
      repeat (n) @(ev_div);
   endtask

   // Monitor
   bit started   = 0;
   bit first_rel = 1;
   bit prev_div  = 0;
   bit fell      = 0;
   bit pref_bad  = 0;
   int t_last    = 0;
   int mcnt      = 0;
   int rst_chk   = 0;
   always @(posedge pre_clk) begin
      #1;
      if (rst_n !== 1'b1) begin
         if (rst_chk < 3) begin
            rst_chk++;
            chk(div_out === 1'b0, "R7 div_out in reset", int'(div_out), 0);
            chk(mode_out === 1'b0, "R7 mode_out in reset", int'(mode_out), 0);
         end
      end else begin
         if (first_rel) begin
            first_rel = 0;
            chk(div_out === 1'b1, "R7 reload on first edge", int'(div_out), 1);
         end
         if (div_out === 1'b1) begin
            chk(!prev_div, "R4 pulse width", 2, 1);
            if (started) begin
               if (q_sp.size() == 0) begin
                  chk(0, "R2 unexpected pulse", hc - t_last, 0);
               end else begin
                  int esp, es;
                  esp = q_sp.pop_front();
                  es  = q_s.pop_front();
                  chk(hc - t_last == esp, "R2/R5 spacing in half periods", hc - t_last, esp);
                  chk(mcnt == es, "R3 swallow periods", mcnt, es);
                  chk(!pref_bad, "R3 mode prefix", 1, 0);
               end
            end
            started  = 1;
            t_last   = hc;
            mcnt     = 0;
            fell     = 0;
            pref_bad = 0;
            -> ev_div;
         end
         if (mode_out === 1'b1) begin
            if (fell) pref_bad = 1;
            mcnt++;
         end else begin
            fell = 1;
         end
         prev_div = (div_out === 1'b1);
      end
   end

   // Watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 60000) begin
         n_errors++;
         $display("FAIL watchdog: actual %0d expected %0d", wd, 60000);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      ratio_cmd = 9'd72;            // R1: P=9, S=0
      push_cmd(72, 3);
      repeat (4) @(posedge pre_clk);
      @(negedge pre_clk);
      rst_n = 1'b1;
      repeat (3) @(ev_div);
      run(167, 3);                  // R1: P=20, S=7
      run(107, 3);                  // P=13, S=3
      run(88, 2);                   // P=11, S=0
      run(10, 2);                   // R6: acts as 72
      run(400, 2);                  // R6: acts as 167
      run(119, 2);                  // P=14, S=7
      run(81, 2);                   // P=10, S=1
      @(ev_div);
      chk(q_sp.size() == 0, "R2 all cycles observed", q_sp.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule